// File: doc/BRIEF.md
# ATA Device Register File

This block is the device-side register file of an ATA disk drive as seen from a byte-wide host bus. The host reads and writes eight addressed registers (data, error/features, sector count, sector number, both cylinder bytes, the device/head byte and status/command) and, through a second select, the alternate status / device control register. The parameter bytes are held here and handed to the command engine as plain outputs. The device/head byte is also split into its fields.

Two jobs run here that the command engine does not handle. When the host writes a command code, the block checks it against the set of codes it recognises and against the presence of the selected drive. A good command is passed on as a one-cycle strobe. A bad one is refused with an abort code in the error register. The block also owns the interrupt line. Any request, whether from a refused command or from the engine, loads a countdown. The line rises when the countdown expires and stays up until the host reads the status register.

The data port, the sector buffer and the command engine sit outside the block. They are reached through read/write strobes, a data input and three condition inputs that feed the status byte.

Top module: `ata_taskfile`

## Requirements
- R1: After reset every parameter register reads 0x00. A host write to offsets 1 through 5 stores the byte, and reading offsets 2 to 5 returns it. The features, count, sector and cylinder outputs follow the stored values, with cylinder high in bits 15:8.
- R2: Offset 6 reads back exactly as written. Its fields are sector size (bits 7:6), the address-mode flag (bit 5), the drive select (bit 4) and the head (bits 3:0), and each field appears on its own output.
- R3: The status byte (offset 7) has these bits:
  - bit 6 (ready) and bit 4 (seek complete) are set when the drive chosen by bit 4 of offset 6 is present;
  - bit 3 (data request) is set when the buffer is non-empty, a write is pending or a packet command requests data;
  - bit 0 is set when the error register is non-zero;
  - all other bits read 0.
- R4: A status read at offset 7 clears the interrupt line on the next edge and cancels any countdown in progress, so that countdown never raises the line.
- R5: A read through the alternate status select returns the same byte as a status read and leaves the interrupt line and the error register unchanged.
- R6: Reading offset 1 returns the error byte and clears it to 0x00 on that edge.
- R7: A command written at offset 7 is refused when the selected drive is absent or the code is not recognised. A refused command sets the error register to 0x04 (abort), issues no command strobe and requests an interrupt. The recognised codes are 08, 10, 20, 30, 91, A0, A1, C4, C5, C6, E1, EC and EF (hex).
- R8: A recognised command for a present drive pulses the command strobe for one cycle after the write, presents the code with it and clears the error register.
- R9: An interrupt request loads a countdown of IRQ_DELAY (default 1). The line rises IRQ_DELAY edges after the edge that takes the request and then stays high until a status read.
- R10: Writing the control register with bit 2 set enters soft reset, and writing it with bit 2 clear leaves soft reset. While in soft reset with the packet-device input high, offset 4 reads 0x14 and offset 5 reads 0xEB. Otherwise those offsets read their stored bytes.
- R11: Offsets at or above 8 read 0x00, and writes to them change no register.
- R12: When an interrupt request and a status read meet on one edge, the line is cleared and the new request is kept, so the line rises IRQ_DELAY edges later.
- R13: A read at offset 0 returns the data input and raises the data read strobe for that cycle. A write at offset 0 raises the data write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Access to the main register window |
| host_wr | input | 1 | 1 = write, 0 = read (both selects) |
| host_addr | input | ADDR_W | Register offset |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte for the current access |
| ctl_sel | input | 1 | Access to alternate status / device control |
| drive_present | input | 2 | Presence of drive 0 and drive 1 |
| packet_dev | input | 1 | Selected drive is a packet device |
| buf_nonempty | input | 1 | Sector buffer holds data |
| write_pending | input | 1 | Write command awaits data |
| packet_drq | input | 1 | Packet command in a data-request phase |
| data_in | input | 8 | Byte from the data port |
| data_rd_stb | output | 1 | Data port read this cycle |
| data_wr_stb | output | 1 | Data port write this cycle |
| irq_req | input | 1 | Interrupt request from the command engine |
| cmd_valid | output | 1 | Accepted command strobe |
| cmd_code | output | 8 | Accepted command code |
| feature | output | 8 | Features byte |
| sect_count | output | 8 | Sector count |
| sect_num | output | 8 | Sector number |
| cyl | output | 16 | Cylinder |
| lba_mode | output | 1 | Address-mode flag |
| drive_sel | output | 1 | Selected drive |
| head_sel | output | 4 | Head number |
| sect_size | output | 2 | Sector-size field |
| irq | output | 1 | Interrupt line |

## Verification
The interrupt countdown and the status-read acknowledge can act on the same edge. That edge decides whether a request is lost or a stale interrupt survives. The bench provokes this in two ways. In the first, it raises the engine's request and a status read in one cycle; the line must be low after that edge and high one edge later. In the second, it places the status read on the edge where the countdown expires; the line must never rise. A scoreboard queue compares the byte returned by each of those reads.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

   localparam logic [7:0] ERR_ABORT = 8'h04;
   localparam logic [7:0] SIG_CYL_LO = 8'h14;
   localparam logic [7:0] SIG_CYL_HI = 8'hEB;
   localparam int         SRST_BIT  = 2;

   localparam int ST_ERR  = 0;
   localparam int ST_DRQ  = 3;
   localparam int ST_DSC  = 4;
   localparam int ST_DRDY = 6;

   typedef enum logic [2:0] {
      OFS_DATA    = 3'd0,
      OFS_ERRFEAT = 3'd1,
      OFS_COUNT   = 3'd2,
      OFS_SECTOR  = 3'd3,
      OFS_CYLLO   = 3'd4,
      OFS_CYLHI   = 3'd5,
      OFS_DEVHEAD = 3'd6,
      OFS_STATCMD = 3'd7
   } tf_ofs_e;

   typedef struct packed {
      logic [1:0] size;
      logic       lba;
      logic       drv;
      logic [3:0] head;
   } devhead_t;

   function automatic logic cmd_known(input logic [7:0] code);
      case (code)
         8'h08, 8'h10, 8'h20, 8'h30, 8'h91, 8'hA0, 8'hA1,
         8'hC4, 8'hC5, 8'hC6, 8'hE1, 8'hEC, 8'hEF: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
   import ata_tf_pkg::*;
#(
   parameter int NREG = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       ofs,
   input  logic [7:0]       wdata,
   input  logic             ctl_wr,
   output logic [NREG*8-1:0] regs_flat,
   output logic             srst
);

   logic [7:0] r_q [1:NREG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 1; i <= NREG; i++) r_q[i] <= 8'h00;
      end else if (wr_en) begin
         for (int i = 1; i <= NREG; i++)
            if (ofs == 3'(i)) r_q[i] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      srst <= 1'b0;
      else if (ctl_wr) srst <= wdata[SRST_BIT];
   end

   generate
      for (genvar g = 1; g <= NREG; g++) begin : g_flat
         assign regs_flat[(g-1)*8 +: 8] = r_q[g];
      end
   endgenerate

endmodule

// File: rtl/ata_tf_cmd.sv
module ata_tf_cmd
   import ata_tf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_wr,
   input  logic [7:0] wdata,
   input  logic       present,
   input  logic       err_rd,
   output logic [7:0] err_q,
   output logic       cmd_valid,
   output logic [7:0] cmd_code,
   output logic       abort_req
);

   logic refuse;
   assign refuse    = !present || !cmd_known(wdata);
   assign abort_req = cmd_wr && refuse;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q     <= 8'h00;
         cmd_valid <= 1'b0;
         cmd_code  <= 8'h00;
      end else begin
         cmd_valid <= 1'b0;
         if (cmd_wr) begin
            if (refuse) begin
               err_q <= ERR_ABORT;
            end else begin
               err_q     <= 8'h00;
               cmd_valid <= 1'b1;
               cmd_code  <= wdata;
            end
         end else if (err_rd) begin
            err_q <= 8'h00;
         end
      end
   end

endmodule

// File: rtl/ata_tf_irq.sv
module ata_tf_irq #(
   parameter int IRQ_DELAY = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic ack,
   output logic irq
);

   localparam int CNT_W = $clog2(IRQ_DELAY + 1);

   generate
      if (IRQ_DELAY == 1) begin : g_flag
         logic pend;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pend <= 1'b0;
               irq  <= 1'b0;
            end else begin
               pend <= req;
               if (ack)       irq <= 1'b0;
               else if (pend) irq <= 1'b1;
            end
         end
      end else begin : g_count
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt <= '0;
               irq <= 1'b0;
            end else begin
               if (req)              cnt <= CNT_W'(IRQ_DELAY);
               else if (ack)         cnt <= '0;
               else if (cnt != '0)   cnt <= cnt - 1'b1;
               if (ack)                       irq <= 1'b0;
               else if (cnt == CNT_W'(1))     irq <= 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
   import ata_tf_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int IRQ_DELAY = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata,
   input  logic              ctl_sel,
   input  logic [1:0]        drive_present,
   input  logic              packet_dev,
   input  logic              buf_nonempty,
   input  logic              write_pending,
   input  logic              packet_drq,
   input  logic [7:0]        data_in,
   output logic              data_rd_stb,
   output logic              data_wr_stb,
   input  logic              irq_req,
   output logic              cmd_valid,
   output logic [7:0]        cmd_code,
   output logic [7:0]        feature,
   output logic [7:0]        sect_count,
   output logic [7:0]        sect_num,
   output logic [15:0]       cyl,
   output logic              lba_mode,
   output logic              drive_sel,
   output logic [3:0]        head_sel,
   output logic [1:0]        sect_size,
   output logic              irq
);

   localparam int NREG = 6;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("ata_taskfile: ADDR_W must be at least 3");
   end
   if (IRQ_DELAY < 1) begin : g_bad_delay
      $error("ata_taskfile: IRQ_DELAY must be at least 1");
   end

   logic in_range;
   generate
      if (ADDR_W > 3) begin : g_wide
         assign in_range = ~|host_addr[ADDR_W-1:3];
      end else begin : g_narrow
         assign in_range = 1'b1;
      end
   endgenerate

   tf_ofs_e ofs;
   assign ofs = tf_ofs_e'(host_addr[2:0]);

   logic acc_rd, acc_wr;
   assign acc_rd = host_sel && !host_wr && in_range;
   assign acc_wr = host_sel &&  host_wr && in_range;

   logic stat_rd, alt_rd, err_rd, cmd_wr, ctl_wr, reg_wr;
   assign stat_rd = acc_rd && ofs == OFS_STATCMD;
   assign err_rd  = acc_rd && ofs == OFS_ERRFEAT;
   assign cmd_wr  = acc_wr && ofs == OFS_STATCMD;
   assign reg_wr  = acc_wr && ofs != OFS_STATCMD && ofs != OFS_DATA;
   assign alt_rd  = ctl_sel && !host_wr;
   assign ctl_wr  = ctl_sel &&  host_wr;

   assign data_rd_stb = acc_rd && ofs == OFS_DATA;
   assign data_wr_stb = acc_wr && ofs == OFS_DATA;

   logic [NREG*8-1:0] regs_flat;
   logic              srst_q;

   ata_tf_regs #(.NREG(NREG)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr),
      .ofs       (host_addr[2:0]),
      .wdata     (host_wdata),
      .ctl_wr    (ctl_wr),
      .regs_flat (regs_flat),
      .srst      (srst_q)
   );

   logic [7:0] r_feat, r_count, r_sect, r_cyllo, r_cylhi;
   devhead_t   r_dh;
   assign r_feat  = regs_flat[0*8 +: 8];
   assign r_count = regs_flat[1*8 +: 8];
   assign r_sect  = regs_flat[2*8 +: 8];
   assign r_cyllo = regs_flat[3*8 +: 8];
   assign r_cylhi = regs_flat[4*8 +: 8];
   assign r_dh    = devhead_t'(regs_flat[5*8 +: 8]);

   assign feature    = r_feat;
   assign sect_count = r_count;
   assign sect_num   = r_sect;
   assign cyl        = {r_cylhi, r_cyllo};
   assign lba_mode   = r_dh.lba;
   assign drive_sel  = r_dh.drv;
   assign head_sel   = r_dh.head;
   assign sect_size  = r_dh.size;

   logic cur_present;
   assign cur_present = drive_present[r_dh.drv];

   logic [7:0] err_q;
   logic       abort_req;

   ata_tf_cmd u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (cmd_wr),
      .wdata     (host_wdata),
      .present   (cur_present),
      .err_rd    (err_rd),
      .err_q     (err_q),
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code),
      .abort_req (abort_req)
   );

   ata_tf_irq #(.IRQ_DELAY(IRQ_DELAY)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (abort_req || irq_req),
      .ack   (stat_rd),
      .irq   (irq)
   );

   logic [7:0] status;
   always_comb begin
      status          = 8'h00;
      status[ST_DRDY] = cur_present;
      status[ST_DSC]  = cur_present;
      status[ST_DRQ]  = buf_nonempty || write_pending || packet_drq;
      status[ST_ERR]  = err_q != 8'h00;
   end

   logic sig_on;
   assign sig_on = srst_q && packet_dev;

   always_comb begin
      host_rdata = 8'h00;
      if (alt_rd) begin
         host_rdata = status;
      end else if (acc_rd) begin
         case (ofs)
            OFS_DATA:    host_rdata = data_in;
            OFS_ERRFEAT: host_rdata = err_q;
            OFS_COUNT:   host_rdata = r_count;
            OFS_SECTOR:  host_rdata = r_sect;
            OFS_CYLLO:   host_rdata = sig_on ? SIG_CYL_LO : r_cyllo;
            OFS_CYLHI:   host_rdata = sig_on ? SIG_CYL_HI : r_cylhi;
            OFS_DEVHEAD: host_rdata = r_dh;
            OFS_STATCMD: host_rdata = status;
            default:     host_rdata = 8'h00;
         endcase
      end
   end

endmodule

// File: rtl/ata_taskfile_chk.sv
module ata_taskfile_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stat_rd,
   input logic              alt_rd,
   input logic              err_rd,
   input logic              cmd_wr,
   input logic              cur_present,
   input logic              irq,
   input logic [7:0]        err_q,
   input logic              cmd_valid,
   input logic              srst_q,
   input logic              packet_dev,
   input logic              host_sel,
   input logic              host_wr,
   input logic [ADDR_W-1:0] host_addr,
   input logic [7:0]        host_rdata
);

   // R4
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> !irq);

   // R5
   alt_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alt_rd && !stat_rd && irq) |=> irq);

   // R9
   rise_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(!stat_rd));

   // R6
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_rd && !cmd_wr) |=> err_q == 8'h00);

   // R7
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !cur_present) |=> (err_q == 8'h04 && !cmd_valid));

   // R8
   dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(cmd_wr && cur_present));

   // R10
   signature_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (srst_q && packet_dev && host_sel && !host_wr && host_addr == ADDR_W'(4))
         |-> host_rdata == 8'h14);

endmodule

bind ata_taskfile ata_taskfile_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .stat_rd     (stat_rd),
   .alt_rd      (alt_rd),
   .err_rd      (err_rd),
   .cmd_wr      (cmd_wr),
   .cur_present (cur_present),
   .irq         (irq),
   .err_q       (err_q),
   .cmd_valid   (cmd_valid),
   .srst_q      (srst_q),
   .packet_dev  (packet_dev),
   .host_sel    (host_sel),
   .host_wr     (host_wr),
   .host_addr   (host_addr),
   .host_rdata  (host_rdata)
);

// File: tb/ata_taskfile_test.sv
module ata_taskfile_test;

   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_sel = 1'b0;
   logic          host_wr = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [7:0]    host_wdata = 8'h00;
   logic [7:0]    host_rdata;
   logic          ctl_sel = 1'b0;
   logic [1:0]    drive_present = 2'b01;
   logic          packet_dev = 1'b0;
   logic          buf_nonempty = 1'b0;
   logic          write_pending = 1'b0;
   logic          packet_drq = 1'b0;
   logic [7:0]    data_in = 8'h00;
   logic          data_rd_stb, data_wr_stb;
   logic          irq_req = 1'b0;
   logic          cmd_valid;
   logic [7:0]    cmd_code, feature, sect_count, sect_num;
   logic [15:0]   cyl;
   logic          lba_mode, drive_sel;
   logic [3:0]    head_sel;
   logic [1:0]    sect_size;
   logic          irq;

   always #5 clk = ~clk;

   ata_taskfile #(.ADDR_W(AW), .IRQ_DELAY(1)) uut (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .ctl_sel(ctl_sel), .drive_present(drive_present), .packet_dev(packet_dev),
      .buf_nonempty(buf_nonempty), .write_pending(write_pending),
      .packet_drq(packet_drq), .data_in(data_in), .data_rd_stb(data_rd_stb),
      .data_wr_stb(data_wr_stb), .irq_req(irq_req), .cmd_valid(cmd_valid),
      .cmd_code(cmd_code), .feature(feature), .sect_count(sect_count),
      .sect_num(sect_num), .cyl(cyl), .lba_mode(lba_mode), .drive_sel(drive_sel),
      .head_sel(head_sel), .sect_size(sect_size), .irq(irq)
   );

   int    compared = 0;
   int    mismatched = 0;
   bit    finished = 1'b0;
   logic [7:0] exp_q [$];
   string      tag_q [$];

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // monitor: pops the expected byte of every read access mid-cycle
   always @(negedge clk) begin
      if (rst_n && !host_wr && (host_sel || ctl_sel)) begin
         compared++;
         if (exp_q.size() == 0) begin
            mismatched++;
            $display("FAIL unexpected read: actual 0x%0h expected none", host_rdata);
         end else begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (host_rdata !== e) begin
               mismatched++;
               $display("FAIL %s: actual 0x%0h expected 0x%0h", t, host_rdata, e);
            end
         end
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(posedge clk); #1;
      host_sel = 1'b0; host_wr = 1'b0;
   endtask

   task automatic ctl_write(input logic [7:0] d);
      @(posedge clk); #1;
      ctl_sel = 1'b1; host_wr = 1'b1; host_wdata = d;
      @(posedge clk); #1;
      ctl_sel = 1'b0; host_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
      exp_q.push_back(e); tag_q.push_back(tag);
      @(posedge clk); #1;
      host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
      @(posedge clk); #1;
      host_sel = 1'b0;
   endtask

   task automatic alt_rd(input logic [7:0] e, input string tag);
      exp_q.push_back(e); tag_q.push_back(tag);
      @(posedge clk); #1;
      ctl_sel = 1'b1; host_wr = 1'b0;
      @(posedge clk); #1;
      ctl_sel = 1'b0;
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         compared++; mismatched++;
         $display("FAIL watchdog: run hung, actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state
      rd(4'd2, 8'h00, "R1 count after reset");
      rd(4'd6, 8'h00, "R2 devhead after reset");
      rd(4'd7, 8'h50, "R3 status after reset");
      rd(4'd1, 8'h00, "R6 error after reset");
      check("R9 irq after reset", irq, 0);

      // parameter registers
      wr(4'd1, 8'h03); wr(4'd2, 8'h5A); wr(4'd3, 8'h11);
      wr(4'd4, 8'h12); wr(4'd5, 8'h34);
      rd(4'd2, 8'h5A, "R1 count");
      rd(4'd3, 8'h11, "R1 sector");
      rd(4'd4, 8'h12, "R1 cyl lo");
      rd(4'd5, 8'h34, "R1 cyl hi");
      check("R1 cyl out", cyl, 16'h3412);
      check("R1 feature out", feature, 8'h03);
      check("R1 count out", sect_count, 8'h5A);

      // device/head packing
      wr(4'd6, 8'hE3);
      rd(4'd6, 8'hE3, "R2 devhead readback");
      check("R2 lba", lba_mode, 1);
      check("R2 head", head_sel, 4'h3);
      check("R2 drive", drive_sel, 0);
      check("R2 size", sect_size, 2'b11);
      rd(4'd7, 8'h50, "R3 status drive0 present");

      // absent drive: refused command
      wr(4'd6, 8'hB0);
      check("R2 drive1", drive_sel, 1);
      rd(4'd7, 8'h00, "R3 status drive1 absent");
      wr(4'd7, 8'h20);
      check("R7 no strobe on refuse", cmd_valid, 0);
      check("R9 irq not yet", irq, 0);
      @(posedge clk); #1;
      check("R9 irq after delay", irq, 1);
      repeat (3) @(posedge clk); #1;
      check("R9 irq held", irq, 1);
      alt_rd(8'h01, "R5 alt status");
      check("R5 irq kept after alt read", irq, 1);
      rd(4'd7, 8'h01, "R3 status err bit");
      check("R4 irq cleared by status read", irq, 0);
      rd(4'd1, 8'h04, "R7 abort code");
      rd(4'd1, 8'h00, "R6 error cleared by read");
      rd(4'd7, 8'h00, "R6 status err bit gone");

      // unknown code on present drive, then recognised code
      wr(4'd6, 8'hA0);
      wr(4'd7, 8'h55);
      check("R7 no strobe unknown", cmd_valid, 0);
      @(posedge clk); #1;
      check("R7 irq on unknown", irq, 1);
      rd(4'd7, 8'h51, "R7 status err after unknown");
      wr(4'd7, 8'hEC);
      check("R8 strobe", cmd_valid, 1);
      check("R8 code", cmd_code, 8'hEC);
      @(posedge clk); #1;
      check("R8 strobe one cycle", cmd_valid, 0);
      check("R8 no irq from accepted", irq, 0);
      rd(4'd1, 8'h00, "R8 error cleared by accepted command");

      // data request sources
      buf_nonempty = 1'b1;
      rd(4'd7, 8'h58, "R3 drq buffer");
      buf_nonempty = 1'b0; write_pending = 1'b1;
      rd(4'd7, 8'h58, "R3 drq write");
      write_pending = 1'b0; packet_drq = 1'b1;
      rd(4'd7, 8'h58, "R3 drq packet");
      packet_drq = 1'b0;
      rd(4'd7, 8'h50, "R3 drq clear");

      // engine request, normal path
      @(posedge clk); #1 irq_req = 1'b1;
      @(posedge clk); #1 irq_req = 1'b0;
      check("R9 engine irq not yet", irq, 0);
      @(posedge clk); #1;
      check("R9 engine irq", irq, 1);
      rd(4'd7, 8'h50, "R4 status ack");
      check("R4 ack cleared", irq, 0);

      // status read on the expiry edge cancels the countdown
      @(posedge clk); #1 irq_req = 1'b1;
      @(posedge clk); #1 irq_req = 1'b0;
      exp_q.push_back(8'h50); tag_q.push_back("R4 cancel read");
      host_sel = 1'b1; host_wr = 1'b0; host_addr = 4'd7;
      @(posedge clk); #1 host_sel = 1'b0;
      repeat (3) @(posedge clk); #1;
      check("R4 countdown cancelled", irq, 0);

      // request and status read on the same edge
      @(posedge clk); #1;
      irq_req = 1'b1;
      exp_q.push_back(8'h50); tag_q.push_back("R12 same-cycle read");
      host_sel = 1'b1; host_wr = 1'b0; host_addr = 4'd7;
      @(posedge clk); #1;
      irq_req = 1'b0; host_sel = 1'b0;
      check("R12 low after joint edge", irq, 0);
      @(posedge clk); #1;
      check("R12 request kept", irq, 1);
      rd(4'd7, 8'h50, "R12 clear");
      check("R12 cleared", irq, 0);

      // soft reset signature
      ctl_write(8'h04);
      rd(4'd4, 8'h12, "R10 non-packet in reset");
      packet_dev = 1'b1;
      rd(4'd4, 8'h14, "R10 signature lo");
      rd(4'd5, 8'hEB, "R10 signature hi");
      ctl_write(8'h00);
      rd(4'd4, 8'h12, "R10 stored lo after release");
      rd(4'd5, 8'h34, "R10 stored hi after release");
      packet_dev = 1'b0;

      // unused offsets
      wr(4'd9, 8'hFF);
      wr(4'd10, 8'h77);
      rd(4'd9, 8'h00, "R11 unused read");
      rd(4'd10, 8'h00, "R11 unused read 10");
      rd(4'd2, 8'h5A, "R11 count untouched");
      rd(4'd6, 8'hA0, "R11 devhead untouched");

      // data port
      data_in = 8'hC3;
      exp_q.push_back(8'hC3); tag_q.push_back("R13 data read");
      @(posedge clk); #1;
      host_sel = 1'b1; host_wr = 1'b0; host_addr = 4'd0;
      #1 check("R13 read strobe", data_rd_stb, 1);
      check("R13 no write strobe", data_wr_stb, 0);
      @(posedge clk); #1 host_sel = 1'b0;
      @(posedge clk); #1;
      host_sel = 1'b1; host_wr = 1'b1; host_addr = 4'd0; host_wdata = 8'h9E;
      #1 check("R13 write strobe", data_wr_stb, 1);
      @(posedge clk); #1 host_sel = 1'b0; host_wr = 1'b0;

      repeat (3) @(posedge clk);
      check("scoreboard drained", exp_q.size(), 0);
      finished = 1'b1;
      summary();
      $finish;
   end

endmodule